// File: doc/BRIEF.md
# Display line and mode sequencer

This block produces the timing state of a raster display with 144 visible lines. A position counter advances one dot each time the cycle enable is high. It wraps after 114 dots, and each wrap advances the line number. After line 153 the line number returns to 0, so a frame is 154 lines. From that position a small state machine derives the 2-bit display mode. A comparator matches the line number against a software-supplied compare value and drives a coincidence flag.

Two interrupt requests come out of the block as single-clock pulses. The blanking-frame request fires every time the sequencer enters the vertical-blank mode. The status request is the OR of four sources, and each source has its own enable: entry to horizontal blank, entry to vertical blank, entry to line search, and the rising edge of the coincidence flag. A source fires only on entry, never while its condition persists. When the display enable is low, the position counters keep running, but the mode and the coincidence flag freeze and no request is raised.

The state machine has four states, and each state's value is the mode code: HBLANK = 0, VBLANK = 1, SEARCH = 2, XFER = 3. The transitions are:
- SEARCH to XFER at dot 20.
- XFER to HBLANK at dot 100.
- HBLANK to SEARCH at the start of the next visible line.
- HBLANK to VBLANK when line 144 begins.
- VBLANK to SEARCH when line 0 begins.

The state register follows the position one clock after the counters change. It moves only while the display is enabled. If the display is re-enabled at some other position, the state jumps straight to the state that position calls for.

Top module: `disp_line_seq`

## Requirements
- R1: `dot` counts 0,1,…,113 on clocks where `tick` is 1, wraps from 113 to 0, and holds when `tick` is 0.
- R2: `line_num` increments by one on each `dot` wrap and returns from 153 to 0.
- R3: On lines 0..143, `mode` follows the dot of the previous clock: 2 for dots 0..19, 3 for dots 20..99, and 0 for dots 100..113.
- R4: On lines 144..153, `mode` becomes 1 (one clock after the position).
- R5: Entering mode 1 raises a one-clock `vblank_req` pulse whatever the enables are. It also raises `stat_req` when `en_vblank` is 1.
- R6: Entering mode 0 raises `stat_req` only if `en_hblank` is 1, and entering mode 2 raises it only if `en_search` is 1. Entering mode 3 raises nothing. A mode that persists raises no further pulse.
- R7: `match_flag` is the registered result of `line_num == cmp_line`. A 0-to-1 change of that result raises `stat_req` only if `en_match` is 1.
- R8: While `disp_on` is 0, `mode` and `match_flag` hold their values and both requests stay 0. `dot` and `line_num` keep counting.
- R9: After reset, `dot`, `line_num`, `mode`, `match_flag`, `vblank_req` and `stat_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Cycle enable; advances the dot counter |
| disp_on | input | 1 | Display enable; gates mode tracking and requests |
| cmp_line | input | 8 | Line compare value |
| en_hblank | input | 1 | Status source enable: horizontal-blank entry |
| en_vblank | input | 1 | Status source enable: vertical-blank entry |
| en_search | input | 1 | Status source enable: line-search entry |
| en_match | input | 1 | Status source enable: coincidence rising edge |
| dot | output | 7 | Dot position within the line |
| line_num | output | 8 | Current line number |
| mode | output | 2 | Display mode code (0 hblank, 1 vblank, 2 search, 3 transfer) |
| match_flag | output | 1 | Coincidence flag |
| vblank_req | output | 1 | One-clock pulse on vertical-blank entry |
| stat_req | output | 1 | One-clock pulse for any enabled status source |

## Verification
The bench goes after the dot-19/20 and dot-99/100 mode edges, the line 143/144 and 153/0 boundaries, and the idle cycles of a sparse `tick`. A design that is off by one at any of these edges shows the wrong mode for a whole dot period. Selected enables are turned off, so a status source that ignores its enable, or a transfer-mode entry that wrongly fires, shows up as an extra pulse. A compare value that stays equal for a whole line catches a level-triggered coincidence request, which would pulse repeatedly instead of once. Turning the display off in the middle of a frame exposes a mode that keeps moving, or a request that leaks while the display is disabled. Turning it back on exposes a missing resynchronizing entry.

// File: rtl/disp_seq_pkg.sv
package disp_seq_pkg;
    typedef enum logic [1:0] {
        MD_HBLANK = 2'd0,
        MD_VBLANK = 2'd1,
        MD_SEARCH = 2'd2,
        MD_XFER   = 2'd3
    } disp_mode_e;
endpackage

// File: rtl/disp_pos_counter.sv
module disp_pos_counter #(
    parameter int LINE_CYCLES = 114,
    parameter int TOTAL_LINES = 154,
    parameter int DOT_W       = 7,
    parameter int LINE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic [DOT_W-1:0]  dot,
    output logic [LINE_W-1:0] line
);
    localparam logic [DOT_W-1:0]  DOT_LAST  = DOT_W'(LINE_CYCLES - 1);
    localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(TOTAL_LINES - 1);

    logic [DOT_W-1:0]  dot_q;
    logic [LINE_W-1:0] line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dot_q  <= '0;
            line_q <= '0;
        end else if (tick) begin
            if (dot_q == DOT_LAST) begin
                dot_q  <= '0;
                line_q <= (line_q == LINE_LAST) ? '0 : line_q + 1'b1;
            end else begin
                dot_q <= dot_q + 1'b1;
            end
        end
    end

    assign dot  = dot_q;
    assign line = line_q;

    // R1
    dot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(dot_q) < LINE_CYCLES);
    // R2
    line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(line_q) < TOTAL_LINES);
    // R1
    dot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && dot_q == DOT_LAST) |=> (dot_q == '0));
    // R2
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && dot_q == DOT_LAST && line_q != LINE_LAST) |=> (line_q == $past(line_q) + 1'b1));
    // R1
    dot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(dot_q));
endmodule

// File: rtl/disp_mode_fsm.sv
module disp_mode_fsm
    import disp_seq_pkg::*;
#(
    parameter int VISIBLE_LINES = 144,
    parameter int SEARCH_CYCLES = 20,
    parameter int XFER_END      = 100,
    parameter int DOT_W         = 7,
    parameter int LINE_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_on,
    input  logic [DOT_W-1:0]  dot,
    input  logic [LINE_W-1:0] line,
    output disp_mode_e        mode,
    output logic              enter_hblank,
    output logic              enter_vblank,
    output logic              enter_search
);
    disp_mode_e state_q, state_d, pos_mode;

    // position decode
    always_comb begin
        if (int'(line) >= VISIBLE_LINES)     pos_mode = MD_VBLANK;
        else if (int'(dot) < SEARCH_CYCLES)  pos_mode = MD_SEARCH;
        else if (int'(dot) < XFER_END)       pos_mode = MD_XFER;
        else                                 pos_mode = MD_HBLANK;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MD_HBLANK;
        else        state_q <= state_d;
    end

    // next state and entry outputs
    always_comb begin
        state_d      = state_q;
        enter_hblank = 1'b0;
        enter_vblank = 1'b0;
        enter_search = 1'b0;
        if (disp_on && pos_mode != state_q) begin
            state_d = pos_mode;
            unique case (pos_mode)
                MD_HBLANK: enter_hblank = 1'b1;
                MD_VBLANK: enter_vblank = 1'b1;
                MD_SEARCH: enter_search = 1'b1;
                MD_XFER:   ;
            endcase
        end
    end

    assign mode = state_q;

    // R5
    vblank_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enter_vblank |=> (state_q == MD_VBLANK));
    // R8
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |=> $stable(state_q));
    // R6
    entry_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({enter_hblank, enter_vblank, enter_search}));
endmodule

// File: rtl/disp_match_unit.sv
module disp_match_unit #(
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_on,
    input  logic [LINE_W-1:0] line,
    input  logic [LINE_W-1:0] cmp,
    output logic              match_flag,
    output logic              match_rise
);
    logic flag_q;
    logic equal_now;

    assign equal_now = (line == cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (disp_on) flag_q <= equal_now;
    end

    assign match_rise = disp_on && equal_now && !flag_q;
    assign match_flag = flag_q;

    // R7
    rise_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_rise |=> flag_q);
    // R8
    flag_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |=> $stable(flag_q));
endmodule

// File: rtl/disp_line_seq.sv
module disp_line_seq
    import disp_seq_pkg::*;
#(
    parameter int  LINE_CYCLES   = 114,
    parameter int  TOTAL_LINES   = 154,
    parameter int  VISIBLE_LINES = 144,
    parameter int  SEARCH_CYCLES = 20,
    parameter int  XFER_END      = 100,
    localparam int DOT_W         = $clog2(LINE_CYCLES),
    localparam int LINE_W        = $clog2(TOTAL_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              disp_on,
    input  logic [LINE_W-1:0] cmp_line,
    input  logic              en_hblank,
    input  logic              en_vblank,
    input  logic              en_search,
    input  logic              en_match,
    output logic [DOT_W-1:0]  dot,
    output logic [LINE_W-1:0] line_num,
    output logic [1:0]        mode,
    output logic              match_flag,
    output logic              vblank_req,
    output logic              stat_req
);
    logic       go_hblank, go_vblank, go_search, eq_rise;
    disp_mode_e mode_s;
    logic       vb_q, st_q;

    disp_pos_counter #(
        .LINE_CYCLES(LINE_CYCLES), .TOTAL_LINES(TOTAL_LINES),
        .DOT_W(DOT_W), .LINE_W(LINE_W)
    ) u_pos (
        .clk(clk), .rst_n(rst_n), .tick(tick), .dot(dot), .line(line_num)
    );

    disp_mode_fsm #(
        .VISIBLE_LINES(VISIBLE_LINES), .SEARCH_CYCLES(SEARCH_CYCLES),
        .XFER_END(XFER_END), .DOT_W(DOT_W), .LINE_W(LINE_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .disp_on(disp_on), .dot(dot), .line(line_num),
        .mode(mode_s), .enter_hblank(go_hblank), .enter_vblank(go_vblank),
        .enter_search(go_search)
    );

    disp_match_unit #(.LINE_W(LINE_W)) u_match (
        .clk(clk), .rst_n(rst_n), .disp_on(disp_on), .line(line_num),
        .cmp(cmp_line), .match_flag(match_flag), .match_rise(eq_rise)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vb_q <= 1'b0;
            st_q <= 1'b0;
        end else begin
            vb_q <= go_vblank;
            st_q <= (go_hblank && en_hblank) || (go_vblank && en_vblank) ||
                    (go_search && en_search) || (eq_rise && en_match);
        end
    end

    assign mode       = mode_s;
    assign vblank_req = vb_q;
    assign stat_req   = st_q;

    // R8
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_on |=> (!vblank_req && !stat_req));
    // R5
    vblank_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_req |-> (mode == 2'd1));
    // R5
    vblank_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vblank_req |=> !vblank_req);
endmodule

// File: tb/test_disp_line_seq.sv
module test_disp_line_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, disp_on = 1'b0;
    logic [7:0] cmp_line = '0;
    logic       en_hblank = 1'b0, en_vblank = 1'b0, en_search = 1'b0, en_match = 1'b0;
    logic [6:0] dot;
    logic [7:0] line_num;
    logic [1:0] mode;
    logic       match_flag, vblank_req, stat_req;

    int checks = 0, fails = 0, cycles = 0;
    bit done = 1'b0;
    bit comparing = 1'b0;
    int vb_count = 0, st_count = 0;
    string phase = "";

    // reference model state
    int m_dot = 0, m_line = 0, m_mode = 0;
    bit m_match = 0, m_vb = 0, m_st = 0;

    always #2 clk = ~clk;

    disp_line_seq i_disp_line_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .disp_on(disp_on), .cmp_line(cmp_line),
        .en_hblank(en_hblank), .en_vblank(en_vblank), .en_search(en_search),
        .en_match(en_match), .dot(dot), .line_num(line_num), .mode(mode),
        .match_flag(match_flag), .vblank_req(vblank_req), .stat_req(stat_req)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", tag, phase, $time, act, exp);
        end
    endtask

    // behavioural reference, one step per clock
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_dot = 0; m_line = 0; m_mode = 0; m_match = 0; m_vb = 0; m_st = 0;
        end else begin
            int want;
            bit eq;
            if (m_line >= 144)   want = 1;
            else if (m_dot < 20) want = 2;
            else if (m_dot < 100) want = 3;
            else                 want = 0;
            eq = (m_line == int'(cmp_line));
            if (disp_on) begin
                m_vb = (want == 1) && (m_mode != 1);
                m_st = ((want != m_mode) && ((want == 0 && en_hblank) ||
                        (want == 1 && en_vblank) || (want == 2 && en_search))) ||
                       (eq && !m_match && en_match);
                m_mode = want;
                m_match = eq;
            end else begin
                m_vb = 0; m_st = 0;
            end
            if (tick) begin
                if (m_dot == 113) begin
                    m_dot = 0;
                    m_line = (m_line == 153) ? 0 : m_line + 1;
                end else m_dot++;
            end
        end
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (comparing && !done) begin
            check("R1 dot", int'(dot), m_dot);
            check("R2 line_num", int'(line_num), m_line);
            if (m_mode == 1) check("R4 mode", int'(mode), m_mode);
            else             check("R3 mode", int'(mode), m_mode);
            check("R7 match_flag", int'(match_flag), int'(m_match));
            check("R5 vblank_req", int'(vblank_req), int'(m_vb));
            check("R6 R7 stat_req", int'(stat_req), int'(m_st));
            if (vblank_req) vb_count++;
            if (stat_req) st_count++;
        end
    end

    task automatic run(input int n, input int period);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = (i % period) == 0;
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        phase = "reset";
        // R9: reset state
        check("R9 dot", int'(dot), 0);
        check("R9 line_num", int'(line_num), 0);
        check("R9 mode", int'(mode), 0);
        check("R9 match_flag", int'(match_flag), 0);
        check("R9 vblank_req", int'(vblank_req), 0);
        check("R9 stat_req", int'(stat_req), 0);
        @(negedge clk);
        rst_n = 1'b1;
        comparing = 1'b1;

        // all sources enabled, dense ticks
        phase = "full";
        disp_on = 1; en_hblank = 1; en_vblank = 1; en_search = 1; en_match = 1;
        cmp_line = 8'd5;
        vb_count = 0;
        run(114 * 154 + 300, 1);
        check("R5 vblank pulses per frame", vb_count, 1);

        // selective enables, sparse ticks, compare inside the blank
        phase = "sparse";
        en_search = 0; en_vblank = 0; en_hblank = 1; en_match = 1;
        cmp_line = 8'd150;
        run(2 * 114 * 154, 2);

        // display off mid-frame
        phase = "off R8";
        disp_on = 0;
        st_count = 0; vb_count = 0;
        run(3000, 1);
        check("R8 requests while off", st_count + vb_count, 0);

        // back on; only coincidence enabled, compare at line 0
        phase = "match";
        disp_on = 1; en_hblank = 0; en_match = 1; cmp_line = 8'd0;
        run(114 * 154 + 500, 1);

        // transfer entry only: no status
        phase = "none";
        en_match = 0; en_hblank = 0; en_vblank = 0; en_search = 0;
        st_count = 0;
        run(300, 1);
        check("R6 stat with all enables off", st_count, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule